// File: doc/BRIEF.md
# Transparent Translation Range Matcher

This block decides, in the same cycle as an access is presented, whether a logical address falls inside one of several programmable windows that skip address translation. It holds a bank of window registers split evenly between instruction accesses and data accesses. Each window compares the most significant address byte against a base byte. A per-bit mask turns chosen bits into don't-care, so one window can span anything from 16 MB to the whole 4 GB space.

On a window hit the logical address is returned unchanged as the physical address. No request is raised towards the translation cache, so that cache is neither read nor updated. A window can be limited to user-mode or supervisor-mode accesses, and it can be marked write-protected. A write that lands in a protected window is flagged as a fault. Software fills the window registers through a single-cycle write port.

Top module: `tt_window_match`

## Requirements
- R1: After reset every window is disabled. Until a register is written, no access hits, and every valid access raises `xlate_req`. This also holds while reset is asserted.
- R2: A window matches when each bit of `acc_addr[31:24]` equals the base bit or its mask bit is 1. The window word keeps the base in bits [7:0] and the mask in bits [15:8]. A mask of 8'hFF covers the whole 4 GB space.
- R3: When `tt_hit` is 1, `phys_addr` equals `acc_addr` in the same cycle. When `tt_hit` is 0, `phys_addr` is zero.
- R4: `tt_hit` can only be 1 while `acc_valid` is 1. `xlate_req` equals `acc_valid` AND NOT `tt_hit`, so a window hit never requests a translation-cache lookup.
- R5: Windows 0 and 1 serve instruction accesses (`acc_is_data`=0) and windows 2 and 3 serve data accesses (`acc_is_data`=1). A window never matches an access of the other type.
- R6: The privilege field sits in bits [18:17]. Value 2'b01 matches only user accesses (`acc_super`=0). Value 2'b10 matches only supervisor accesses. Values 2'b00 and 2'b11 match both.
- R7: Bit 19 is write-protect. `wp_fault` is 1 exactly when the selected window has this bit set and `acc_write` is 1. `tt_hit` stays 1 in that case.
- R8: When two windows of the same access type both match, `tt_win` reports the lower-numbered window, and that window's write-protect bit decides `wp_fault`.
- R9: Bit 16 enables a window. A window with this bit at 0 never matches, whatever its other fields hold.
- R10: A write with `cfg_we`=1 replaces the window chosen by `cfg_sel` at the rising clock edge, and leaves the other windows unchanged. Lookups in the cycle of the write still use the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the window registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Index of the window being written |
| cfg_wdata | input | 20 | New window word: base, mask, enable, privilege, write-protect |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Logical address of the access |
| acc_is_data | input | 1 | 1 for a data access, 0 for an instruction access |
| acc_super | input | 1 | 1 for a supervisor-mode access |
| acc_write | input | 1 | 1 for a write access |
| tt_hit | output | 1 | The address lies in an enabled, qualifying window |
| tt_win | output | 2 | Index of the window that supplied the result |
| phys_addr | output | 32 | Untranslated physical address on a hit, zero otherwise |
| wp_fault | output | 1 | Write into a write-protected window |
| xlate_req | output | 1 | Valid access that needs the translation cache |

## Verification
The bench probes the mask edges of a window: the last address inside, the first address outside, and an address that differs only in a compared top bit. A design that treated mask bits with the wrong polarity, or compared the wrong byte, would hit or miss on the wrong side of these edges. It sets up overlapping windows, so a design that resolved priority from the top down would report window 1 or 3 and take the wrong write-protect bit. Accesses are sent to the opposite access type and to the opposite privilege level, so a window that leaked across either qualifier would hit. The bench also reprograms a window while an access is live, which shows whether a design applies the new contents before the clock edge.

// File: rtl/tt_pkg.sv
package tt_pkg;

   // Extra control bits that follow base and mask in a window word
   localparam int TT_CTRL_BITS = 4;

   typedef enum logic [1:0] {
      PRIV_EITHER     = 2'b00,
      PRIV_USER_ONLY  = 2'b01,
      PRIV_SUPER_ONLY = 2'b10,
      PRIV_EITHER_ALT = 2'b11
   } tt_priv_e;

   function automatic int tt_cfg_width(input int cmp_w);
      return 2 * cmp_w + TT_CTRL_BITS;
   endfunction

   function automatic logic tt_priv_ok(input tt_priv_e mode, input logic is_super);
      logic ok;
      case (mode)
         PRIV_USER_ONLY:  ok = ~is_super;
         PRIV_SUPER_ONLY: ok = is_super;
         default:         ok = 1'b1;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/tt_cfg_regs.sv
module tt_cfg_regs #(
   parameter int NUM_WIN = 4,
   parameter int CFG_W   = 20,
   parameter int SEL_W   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [SEL_W-1:0]           wr_sel,
   input  logic [CFG_W-1:0]           wr_data,
   output logic [NUM_WIN*CFG_W-1:0]   cfg_flat
);

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      logic [CFG_W-1:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_en && (int'(wr_sel) == g)) begin
            word_q <= wr_data;
         end
      end

      assign cfg_flat[g*CFG_W +: CFG_W] = word_q;
   end

endmodule

// File: rtl/tt_win_cmp.sv
module tt_win_cmp #(
   parameter int CMP_W = 8,
   parameter int CFG_W = 2 * CMP_W + 4
) (
   input  logic [CFG_W-1:0] cfg,
   input  logic [CMP_W-1:0] addr_top,
   input  logic             is_super,
   output logic             match,
   output logic             wprot
);
   import tt_pkg::*;

   localparam int MASK_LO = CMP_W;
   localparam int EN_BIT  = 2 * CMP_W;
   localparam int PRIV_LO = EN_BIT + 1;
   localparam int WP_BIT  = PRIV_LO + 2;

   logic [CMP_W-1:0] base;
   logic [CMP_W-1:0] dont_care;
   logic             enabled;
   tt_priv_e         mode;
   logic             bits_ok;

   always_comb begin
      base      = cfg[CMP_W-1:0];
      dont_care = cfg[MASK_LO +: CMP_W];
      enabled   = cfg[EN_BIT];
      mode      = tt_priv_e'(cfg[PRIV_LO +: 2]);
      bits_ok   = &(~(addr_top ^ base) | dont_care);
      match     = enabled & bits_ok & tt_priv_ok(mode, is_super);
      wprot     = cfg[WP_BIT];
   end

endmodule

// File: rtl/tt_prio_sel.sv
module tt_prio_sel #(
   parameter int N     = 4,
   parameter int SEL_W = 2
) (
   input  logic [N-1:0]     req,
   input  logic [N-1:0]     attr,
   output logic             any,
   output logic [SEL_W-1:0] idx,
   output logic             attr_sel
);

   if (N == 1) begin : g_single
      assign any      = req[0];
      assign idx      = '0;
      assign attr_sel = req[0] & attr[0];
   end else begin : g_multi
      always_comb begin
         any      = 1'b0;
         idx      = '0;
         attr_sel = 1'b0;
         // walk downwards so the lowest requesting index is kept last
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               any      = 1'b1;
               idx      = SEL_W'(i);
               attr_sel = attr[i];
            end
         end
      end
   end

endmodule

// File: rtl/tt_window_match.sv
module tt_window_match #(
   parameter  int ADDR_W       = 32,
   parameter  int CMP_W        = 8,
   parameter  int WIN_PER_TYPE = 2,
   localparam int NUM_WIN      = 2 * WIN_PER_TYPE,
   localparam int SEL_W        = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int CFG_W        = 2 * CMP_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_is_data,
   input  logic              acc_super,
   input  logic              acc_write,
   output logic              tt_hit,
   output logic [SEL_W-1:0]  tt_win,
   output logic [ADDR_W-1:0] phys_addr,
   output logic              wp_fault,
   output logic              xlate_req
);

   if (CMP_W < 1 || CMP_W > ADDR_W) begin : g_bad_cmp
      $error("tt_window_match: CMP_W must lie in 1..ADDR_W");
   end
   if (WIN_PER_TYPE < 1) begin : g_bad_win
      $error("tt_window_match: WIN_PER_TYPE must be at least 1");
   end
   if (CFG_W != tt_pkg::tt_cfg_width(CMP_W)) begin : g_bad_cfg
      $error("tt_window_match: window word width mismatch");
   end

   logic [NUM_WIN*CFG_W-1:0] cfg_flat;
   logic [NUM_WIN-1:0]       raw_match;
   logic [NUM_WIN-1:0]       win_wp;
   logic [NUM_WIN-1:0]       qual_match;
   logic [CMP_W-1:0]         addr_top;
   logic                     any_hit;
   logic [SEL_W-1:0]         hit_idx;
   logic                     hit_wp;

   assign addr_top = acc_addr[ADDR_W-1 -: CMP_W];

   tt_cfg_regs #(
      .NUM_WIN (NUM_WIN),
      .CFG_W   (CFG_W),
      .SEL_W   (SEL_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_wdata),
      .cfg_flat (cfg_flat)
   );

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
      localparam bit IS_DATA_WIN = (g >= WIN_PER_TYPE);

      tt_win_cmp #(
         .CMP_W (CMP_W),
         .CFG_W (CFG_W)
      ) u_cmp (
         .cfg      (cfg_flat[g*CFG_W +: CFG_W]),
         .addr_top (addr_top),
         .is_super (acc_super),
         .match    (raw_match[g]),
         .wprot    (win_wp[g])
      );

      assign qual_match[g] = raw_match[g] & acc_valid & (acc_is_data == IS_DATA_WIN);
   end

   tt_prio_sel #(
      .N     (NUM_WIN),
      .SEL_W (SEL_W)
   ) u_prio (
      .req      (qual_match),
      .attr     (win_wp),
      .any      (any_hit),
      .idx      (hit_idx),
      .attr_sel (hit_wp)
   );

   always_comb begin
      tt_hit    = any_hit;
      tt_win    = hit_idx;
      phys_addr = any_hit ? acc_addr : '0;
      wp_fault  = any_hit & hit_wp & acc_write;
      xlate_req = acc_valid & ~any_hit;
   end

endmodule

// File: rtl/tt_window_match_chk.sv
module tt_window_match_chk #(
   parameter  int ADDR_W       = 32,
   parameter  int WIN_PER_TYPE = 2,
   localparam int NUM_WIN      = 2 * WIN_PER_TYPE,
   localparam int SEL_W        = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_is_data,
   input logic              acc_write,
   input logic              tt_hit,
   input logic [SEL_W-1:0]  tt_win,
   input logic [ADDR_W-1:0] phys_addr,
   input logic              wp_fault,
   input logic              xlate_req
);

   logic seen_cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_cfg <= 1'b0;
      end else if (cfg_we) begin
         seen_cfg <= 1'b1;
      end
   end

   assert_clean_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_cfg |-> !tt_hit);

   assert_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tt_hit |-> (phys_addr == acc_addr));

   assert_zero_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !tt_hit |-> (phys_addr == '0));

   assert_hit_or_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> (tt_hit != xlate_req));

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!tt_hit && !xlate_req));

   assert_type_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tt_hit |-> ((int'(tt_win) >= WIN_PER_TYPE) == acc_is_data));

   assert_fault_needs_write_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wp_fault |-> (tt_hit && acc_write));

endmodule

bind tt_window_match tt_window_match_chk #(
   .ADDR_W       (ADDR_W),
   .WIN_PER_TYPE (WIN_PER_TYPE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .acc_valid   (acc_valid),
   .acc_addr    (acc_addr),
   .acc_is_data (acc_is_data),
   .acc_write   (acc_write),
   .tt_hit      (tt_hit),
   .tt_win      (tt_win),
   .phys_addr   (phys_addr),
   .wp_fault    (wp_fault),
   .xlate_req   (xlate_req)
);

// File: tb/sim_tt_window_match.sv
module sim_tt_window_match;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [19:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_is_data = 1'b0;
   logic        acc_super = 1'b0;
   logic        acc_write = 1'b0;
   logic        tt_hit;
   logic [1:0]  tt_win;
   logic [31:0] phys_addr;
   logic        wp_fault;
   logic        xlate_req;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   tt_window_match u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_is_data(acc_is_data), .acc_super(acc_super), .acc_write(acc_write),
      .tt_hit(tt_hit), .tt_win(tt_win), .phys_addr(phys_addr),
      .wp_fault(wp_fault), .xlate_req(xlate_req)
   );

   // window words: [7:0] base, [15:8] mask, [16] enable, [18:17] privilege, [19] write-protect
   localparam logic [19:0] W0_CFG     = 20'h10F40; // 0x40..0x4F, either, no wp
   localparam logic [19:0] W1_CFG     = 20'hD0040; // 0x40 only, supervisor, wp
   localparam logic [19:0] W2_CFG     = 20'hB7F80; // 0x80..0xFF, user, wp
   localparam logic [19:0] W3_CFG     = 20'h1FF00; // whole space, either
   localparam logic [19:0] W0_OFF     = 20'h00F40; // enable cleared
   localparam logic [19:0] W1_EITHER  = 20'h70040; // privilege 2'b11, no wp

   // {valid, is_data, super, write, addr, exp_hit, exp_win, exp_fault}
   localparam int NVEC = 13;
   localparam logic [39:0] VEC [NVEC] = '{
      {4'b1000, 32'h4000_1234, 1'b1, 2'd0, 1'b0},  // R2 inside w0
      {4'b1001, 32'h4F00_0000, 1'b1, 2'd0, 1'b0},  // R2 top edge, R7 unprotected write
      {4'b1010, 32'h5000_0000, 1'b0, 2'd0, 1'b0},  // R2 first outside
      {4'b1000, 32'hC000_0000, 1'b0, 2'd0, 1'b0},  // R2 compared top bit differs
      {4'b1011, 32'h4000_0010, 1'b1, 2'd0, 1'b0},  // R8 w0 and w1 overlap
      {4'b1100, 32'h4000_0000, 1'b1, 2'd3, 1'b0},  // R5 data ignores w0
      {4'b1100, 32'h9000_0000, 1'b1, 2'd2, 1'b0},  // R6 user in user-only w2
      {4'b1101, 32'h9000_0000, 1'b1, 2'd2, 1'b1},  // R7 protected write
      {4'b1111, 32'h9000_0000, 1'b1, 2'd3, 1'b0},  // R6 supervisor skips w2
      {4'b1110, 32'h0000_0000, 1'b1, 2'd3, 1'b0},  // R2 full-space mask
      {4'b1100, 32'hFFFF_FFFC, 1'b1, 2'd2, 1'b0},  // R8 w2 over w3
      {4'b1000, 32'h8000_0000, 1'b0, 2'd0, 1'b0},  // R5 instruction ignores data windows
      {4'b0101, 32'h9000_0000, 1'b0, 2'd0, 1'b0}   // R4 no valid, no activity
   };

   function automatic logic [36:0] pack_out(input logic h, input logic [1:0] w,
                                            input logic f, input logic x,
                                            input logic [31:0] p);
      return {h, w, f, x, p};
   endfunction

   task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [36:0] expect_of(input logic v, input logic h,
                                             input logic [1:0] w, input logic f,
                                             input logic [31:0] a);
      return pack_out(h, h ? w : 2'd0, f, v & ~h, h ? a : 32'd0);
   endfunction

   function automatic logic [36:0] actual_now();
      return pack_out(tt_hit, tt_hit ? tt_win : 2'd0, wp_fault, xlate_req, phys_addr);
   endfunction

   task automatic drive(input logic v, input logic d, input logic s, input logic w,
                        input logic [31:0] a);
      acc_valid   = v;
      acc_is_data = d;
      acc_super   = s;
      acc_write   = w;
      acc_addr    = a;
   endtask

   task automatic wr_cfg(input logic [1:0] sel, input logic [19:0] data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = data;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic look(input string tag, input logic v, input logic d, input logic s,
                       input logic w, input logic [31:0] a, input logic h,
                       input logic [1:0] win, input logic f);
      @(negedge clk);
      drive(v, d, s, w, a);
      #2;
      check(tag, actual_now(), expect_of(v, h, win, f, a));
   endtask

   initial begin
      // R1: reset state, checked while reset is held
      drive(1'b1, 1'b0, 1'b1, 1'b0, 32'h4000_0000);
      repeat (3) @(negedge clk);
      #2;
      check("R1 during reset", actual_now(), expect_of(1'b1, 1'b0, 2'd0, 1'b0, 32'h4000_0000));
      rst_n = 1'b1;
      look("R1 after reset data", 1'b1, 1'b1, 1'b0, 1'b1, 32'h9000_0000, 1'b0, 2'd0, 1'b0);

      wr_cfg(2'd0, W0_CFG);
      wr_cfg(2'd1, W1_CFG);
      wr_cfg(2'd2, W2_CFG);
      wr_cfg(2'd3, W3_CFG);

      for (int i = 0; i < NVEC; i++) begin
         logic [39:0] v;
         v = VEC[i];
         look($sformatf("vector %0d", i), v[39], v[38], v[37], v[36], v[35:4],
              v[3], v[2:1], v[0]);
      end

      // R10: write in flight does not affect this cycle, only the next
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = 2'd0;
      cfg_wdata = W0_OFF;
      drive(1'b1, 1'b0, 1'b1, 1'b1, 32'h4000_0000);
      #2;
      check("R10 old contents in write cycle", actual_now(),
            expect_of(1'b1, 1'b1, 2'd0, 1'b0, 32'h4000_0000));
      @(negedge clk);
      cfg_we = 1'b0;
      #2;
      // R9: w0 disabled, w1 now hits; R7 its write-protect faults
      check("R9 R7 disabled w0 gives w1", actual_now(),
            expect_of(1'b1, 1'b1, 2'd1, 1'b1, 32'h4000_0000));
      // R6: supervisor-only w1 rejects user
      look("R6 user vs supervisor-only", 1'b1, 1'b0, 1'b0, 1'b0, 32'h4000_0000,
           1'b0, 2'd0, 1'b0);
      // R10: other windows untouched by the w0 write
      look("R10 w2 unchanged", 1'b1, 1'b1, 1'b0, 1'b1, 32'hA000_0000, 1'b1, 2'd2, 1'b1);
      // R9: disabled w0 misses an address only it covered
      look("R9 disabled w0 misses", 1'b1, 1'b0, 1'b0, 1'b0, 32'h4500_0000,
           1'b0, 2'd0, 1'b0);
      // R6: privilege code 2'b11 accepts both levels
      wr_cfg(2'd1, W1_EITHER);
      look("R6 code 11 user", 1'b1, 1'b0, 1'b0, 1'b1, 32'h40AB_CDEF, 1'b1, 2'd1, 1'b0);
      look("R6 code 11 supervisor", 1'b1, 1'b0, 1'b1, 1'b0, 32'h4000_0004, 1'b1, 2'd1, 1'b0);

      // R1: a second reset clears every window again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      look("R1 re-reset clears", 1'b1, 1'b1, 1'b0, 1'b0, 32'h1234_5678, 1'b0, 2'd0, 1'b0);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule